// File: doc/BRIEF.md
# Control Word and Training Inserter

This block sits at the output end of a 16-bit packet transmit path. Each cycle it emits one 16-bit word with a flag that marks it as a control word or a payload word. It passes payload through, and it adds a control word only when the destination port changes or when the source runs short of data. It records end-of-packet status, including the abort case, in the control word that closes a burst. It computes a 4-bit diagonal interleaved parity over each burst and writes it into every control word.

On a programmable interval, and back to back for as long as the status receiver reports a continuous framing pattern, the block replaces the word flow with a fixed training sequence. The source offers one word at a time through `in_avail` and sees it taken when `in_ready` is high in the same cycle. A word taken in cycle t appears on `out_data` after the clock edge that ends cycle t. Reset is asynchronous and active low, and the system releases it synchronously to `clk`.

Top module: `ctl_train_inserter`

## Requirements
- R1: While reset is asserted, and straight after it, the output is the idle control word 0x000F with `out_ctl` = 1, and `in_ready` is 0.
- R2: A word offered for the same port as the previous output, when the previous output was a payload word and no end-of-packet status is pending, is taken in that cycle (`in_ready` = 1). It appears unchanged with `out_ctl` = 0 one cycle later, and no control word is placed before it.
- R3: A payload control word is emitted instead of the offered word, which is held (`in_ready` = 0), when the port differs from that of the last burst, or the previous output was not a payload word, or end-of-packet status is pending. Its layout is: bit 15 = 1, bit 12 = `in_sop`, bits 11:4 = `in_port`, bits 3:0 = parity.
- R4: Bits 14:13 of the control word that follows a word taken with `in_eop` = 1 carry 01 when `in_err` was 1, 11 when `in_odd` was 1, and 10 otherwise. They carry 00 in every other control word. `in_err` without `in_eop` has no effect.
- R5: In a cycle with no offered word and no training, the output is an idle control word. Bits 15 and 12:4 are zero, and bits 14:13 hold any pending end-of-packet status.
- R6: The parity field is computed as follows. A 16-bit accumulator takes each payload word w as acc = rotl1(acc) ^ w and is cleared by every control word. For a control word c, x = rotl1(acc) ^ (c with bits 3:0 = 1111), and parity bit i = x[i] ^ x[i+4] ^ x[i+8] ^ x[i+12]. Training words do not enter the accumulator.
- R7: With `cfg_train_gap` = G > 0, a training sequence starts after exactly G non-training words since reset or since the end of the previous sequence. G = 0 disables periodic training.
- R8: A training sequence is 201 words: one idle control word, then 10 repetitions of ten control words 0x0FFF followed by ten payload-flagged words 0xF000. No input word is taken during it.
- R9: While `stat_framing` is 1 at the end of a sequence, the next sequence starts in the following cycle with no word in between. Asserting it outside training starts a sequence in the next cycle.
- R10: The first word of a sequence is an idle control word that carries any pending end-of-packet status, with parity over the burst before it. After the sequence, the next offered word is preceded by a payload control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_avail | input | 1 | A payload word is offered; low means the source is starved |
| in_data | input | 16 | Offered payload word |
| in_port | input | 8 | Destination port of the offered word |
| in_sop | input | 1 | Offered word starts a packet |
| in_eop | input | 1 | Offered word ends a packet |
| in_err | input | 1 | Packet ended by this word is errored |
| in_odd | input | 1 | Last word of the packet holds one valid byte |
| in_ready | output | 1 | Offered word is taken this cycle |
| cfg_train_gap | input | GAP_W | Words between training sequences; 0 disables periodic training |
| stat_framing | input | 1 | Status receiver sees continuous framing |
| out_data | output | 16 | Output word |
| out_ctl | output | 1 | Output word is a control word |

## Verification
A table-driven stream alternates bursts on one port, port changes, starvation gaps and every end-of-packet flavour. This separates the same-port pass-through path from each of the three reasons for a payload control word. It also shows that an errored word without an end-of-packet flag does not produce an abort code. Parity is compared on every control word, which exposes wrong accumulation, wrong clearing and a wrong fold. A run with data starved and a short interval checks the exact start of periodic training and the full 201-word content, and a long run with interval zero checks that training stays off. A framing run entered mid-packet shows that the pending end-of-packet status is closed in the first training word, that sequences repeat back to back, and that a payload control word resumes traffic.

// File: rtl/cwi_pkg.sv
package cwi_pkg;
  localparam int PORT_W = 8;
  localparam logic [15:0] TRAIN_CTL = 16'h0FFF;
  localparam logic [15:0] TRAIN_DAT = 16'hF000;

  typedef enum logic [1:0] {
    EOP_NONE  = 2'b00,
    EOP_ABORT = 2'b01,
    EOP_EVEN  = 2'b10,
    EOP_ODD   = 2'b11
  } eop_code_e;

  function automatic logic [15:0] rotl1(input logic [15:0] w);
    return {w[14:0], w[15]};
  endfunction

  // Fold 16 bits into 4 by XOR of every fourth bit.
  function automatic logic [3:0] fold4(input logic [15:0] x);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = x[i] ^ x[i+4] ^ x[i+8] ^ x[i+12];
    return r;
  endfunction

  // Control word with parity field preset to all ones.
  function automatic logic [15:0] ctl_base(input logic pay, input eop_code_e e,
                                           input logic sop, input logic [PORT_W-1:0] port);
    return {pay, e, sop, port, 4'hF};
  endfunction
endpackage

// File: rtl/cwi_dip.sv
module cwi_dip
  import cwi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_en,
  input  logic        clr_en,
  input  logic [15:0] upd_word,
  input  logic [15:0] ctl_word,
  output logic [3:0]  dip
);
  logic [15:0] acc_q, acc_d;

  assign dip = fold4(rotl1(acc_q) ^ ctl_word);

  always_comb begin
    acc_d = acc_q;
    if (clr_en)      acc_d = '0;
    else if (upd_en) acc_d = rotl1(acc_q) ^ upd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 acc_q <= '0;
    else if (clr_en || upd_en)  acc_q <= acc_d;
  end
endmodule

// File: rtl/cwi_train.sv
module cwi_train
  import cwi_pkg::*;
#(
  parameter int REPS = 10,
  parameter int RUN  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        active,
  output logic [15:0] word,
  output logic        is_ctl
);
  localparam int PH_W  = $clog2(2 * RUN);
  localparam int REP_W = $clog2(REPS + 1);
  localparam logic [PH_W-1:0]  PH_END  = PH_W'(2 * RUN - 1);
  localparam logic [PH_W-1:0]  PH_HALF = PH_W'(RUN);
  localparam logic [REP_W-1:0] REP_END = REP_W'(REPS - 1);

  logic             active_q, active_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             seq_last;

  assign seq_last = (ph_q == PH_END) && (rep_q == REP_END);

  always_comb begin
    active_d = active_q;
    ph_d     = ph_q;
    rep_d    = rep_q;
    if (active_q) begin
      if (seq_last) begin
        active_d = 1'b0;
        ph_d     = '0;
        rep_d    = '0;
      end else if (ph_q == PH_END) begin
        ph_d  = '0;
        rep_d = rep_q + REP_W'(1);
      end else begin
        ph_d = ph_q + PH_W'(1);
      end
    end else if (start) begin
      active_d = 1'b1;
      ph_d     = '0;
      rep_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      rep_q    <= '0;
    end else if (active_q || start) begin
      active_q <= active_d;
      ph_q     <= ph_d;
      rep_q    <= rep_d;
    end
  end

  assign active = active_q;
  assign is_ctl = (ph_q < PH_HALF);
  assign word   = is_ctl ? TRAIN_CTL : TRAIN_DAT;
endmodule

// File: rtl/cwi_gap.sv
module cwi_gap #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap,
  input  logic             tick,
  input  logic             clr,
  output logic             due
);
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             gap_on;

  assign gap_on = (gap != '0);
  assign due    = gap_on && (cnt_q >= gap);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                                  cnt_d = '0;
    else if (tick && gap_on && cnt_q != '1)   cnt_d = cnt_q + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || tick)  cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ctl_train_inserter.sv
module ctl_train_inserter
  import cwi_pkg::*;
#(
  parameter int GAP_W      = 16,
  parameter int TRAIN_REPS = 10,
  parameter int TRAIN_RUN  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_avail,
  input  logic [15:0]       in_data,
  input  logic [PORT_W-1:0] in_port,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_err,
  input  logic              in_odd,
  output logic              in_ready,
  input  logic [GAP_W-1:0]  cfg_train_gap,
  input  logic              stat_framing,
  output logic [15:0]       out_data,
  output logic              out_ctl
);
  localparam logic [15:0] IDLE_RST = 16'h000F;

  logic              tr_active, tr_is_ctl;
  logic [15:0]       tr_word;
  logic              gap_due, train_go, need_ctl, take, pay_ctl;
  logic [15:0]       ctl_pre;
  logic [3:0]        dip;

  logic [15:0]       out_q, out_d;
  logic              ctl_q, ctl_d;
  logic              last_data_q, last_data_d;
  logic [PORT_W-1:0] last_port_q, last_port_d;
  eop_code_e         pend_q, pend_d;

  // Decision for the current word slot.
  assign train_go = !tr_active && (stat_framing || gap_due);
  assign need_ctl = !last_data_q || (in_port != last_port_q) || (pend_q != EOP_NONE);
  assign take     = !tr_active && !train_go && in_avail && !need_ctl;
  assign pay_ctl  = !tr_active && !train_go && in_avail && need_ctl;
  assign in_ready = take;

  assign ctl_pre = pay_ctl ? ctl_base(1'b1, pend_q, in_sop, in_port)
                           : ctl_base(1'b0, pend_q, 1'b0, '0);

  cwi_dip u_dip (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (take),
    .clr_en   (!take),
    .upd_word (in_data),
    .ctl_word (ctl_pre),
    .dip      (dip)
  );

  cwi_train #(.REPS(TRAIN_REPS), .RUN(TRAIN_RUN)) u_train (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (train_go),
    .active (tr_active),
    .word   (tr_word),
    .is_ctl (tr_is_ctl)
  );

  cwi_gap #(.GAP_W(GAP_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .gap   (cfg_train_gap),
    .tick  (!tr_active && !train_go),
    .clr   (train_go),
    .due   (gap_due)
  );

  always_comb begin
    out_d       = out_q;
    ctl_d       = ctl_q;
    last_data_d = last_data_q;
    last_port_d = last_port_q;
    pend_d      = pend_q;
    if (tr_active) begin
      out_d       = tr_word;
      ctl_d       = tr_is_ctl;
      last_data_d = 1'b0;
    end else if (take) begin
      out_d       = in_data;
      ctl_d       = 1'b0;
      last_data_d = 1'b1;
      if (in_eop) pend_d = in_err ? EOP_ABORT : (in_odd ? EOP_ODD : EOP_EVEN);
      else        pend_d = EOP_NONE;
    end else begin
      // Idle, payload or first training control word.
      out_d       = {ctl_pre[15:4], dip};
      ctl_d       = 1'b1;
      pend_d      = EOP_NONE;
      last_data_d = pay_ctl;
      if (pay_ctl) last_port_d = in_port;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q       <= IDLE_RST;
      ctl_q       <= 1'b1;
      last_data_q <= 1'b0;
      last_port_q <= '0;
      pend_q      <= EOP_NONE;
    end else begin
      out_q       <= out_d;
      ctl_q       <= ctl_d;
      last_data_q <= last_data_d;
      last_port_q <= last_port_d;
      pend_q      <= pend_d;
    end
  end

  assign out_data = out_q;
  assign out_ctl  = ctl_q;
endmodule

// File: rtl/cwi_checker.sv
module cwi_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_avail,
  input logic        in_ready,
  input logic [15:0] in_data,
  input logic        in_eop,
  input logic        stat_framing,
  input logic [15:0] out_data,
  input logic        out_ctl,
  input logic        tr_active
);
  // R2: a taken word comes out unchanged as payload one cycle later
  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (!out_ctl && out_data == $past(in_data)));

  // R3: nothing is taken unless a word is offered
  a_r3_take_needs_offer: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_avail);

  // R4: the word after an end-of-packet payload word is a control word
  a_r4_eop_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_eop) |-> ##2 out_ctl);

  // R8: no input is taken while a sequence runs
  a_r8_train_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    tr_active |-> !in_ready);

  // R9: framing outside training starts a sequence at once
  a_r9_framing_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_framing && !tr_active) |=> tr_active);
endmodule

bind ctl_train_inserter cwi_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_avail     (in_avail),
  .in_ready     (in_ready),
  .in_data      (in_data),
  .in_eop       (in_eop),
  .stat_framing (stat_framing),
  .out_data     (out_data),
  .out_ctl      (out_ctl),
  .tr_active    (tr_active)
);

// File: tb/sim_ctl_train_inserter.sv
module sim_ctl_train_inserter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_avail, in_sop, in_eop, in_err, in_odd, in_ready;
  logic [15:0] in_data;
  logic [7:0]  in_port;
  logic [15:0] cfg_train_gap;
  logic        stat_framing;
  logic [15:0] out_data;
  logic        out_ctl;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] b_acc;

  always #5 clk = ~clk;

  ctl_train_inserter u0 (
    .clk(clk), .rst_n(rst_n), .in_avail(in_avail), .in_data(in_data),
    .in_port(in_port), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
    .in_odd(in_odd), .in_ready(in_ready), .cfg_train_gap(cfg_train_gap),
    .stat_framing(stat_framing), .out_data(out_data), .out_ctl(out_ctl)
  );

  // {avail, sop,eop,err,odd, port, data, exp_ready, exp_ctl, exp_base}
  localparam logic [46:0] VEC [22] = '{
    {1'b0, 4'b0000, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h0000},
    {1'b1, 4'b1000, 8'h12, 16'h1111, 1'b0, 1'b1, 16'h9120},
    {1'b1, 4'b1000, 8'h12, 16'h1111, 1'b1, 1'b0, 16'h1111},
    {1'b1, 4'b0000, 8'h12, 16'h2222, 1'b1, 1'b0, 16'h2222},
    {1'b1, 4'b0100, 8'h12, 16'h3333, 1'b1, 1'b0, 16'h3333},
    {1'b1, 4'b1000, 8'h12, 16'h4444, 1'b0, 1'b1, 16'hD120},
    {1'b1, 4'b1000, 8'h12, 16'h4444, 1'b1, 1'b0, 16'h4444},
    {1'b1, 4'b1000, 8'h34, 16'h5555, 1'b0, 1'b1, 16'h9340},
    {1'b1, 4'b1000, 8'h34, 16'h5555, 1'b1, 1'b0, 16'h5555},
    {1'b1, 4'b0110, 8'h34, 16'h6666, 1'b1, 1'b0, 16'h6666},
    {1'b0, 4'b0000, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h2000},
    {1'b0, 4'b0000, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h0000},
    {1'b1, 4'b1101, 8'h34, 16'h7777, 1'b0, 1'b1, 16'h9340},
    {1'b1, 4'b1101, 8'h34, 16'h7777, 1'b1, 1'b0, 16'h7777},
    {1'b1, 4'b1010, 8'h34, 16'h8888, 1'b0, 1'b1, 16'hF340},
    {1'b1, 4'b1010, 8'h34, 16'h8888, 1'b1, 1'b0, 16'h8888},
    {1'b1, 4'b0100, 8'h56, 16'h9999, 1'b0, 1'b1, 16'h8560},
    {1'b1, 4'b0100, 8'h56, 16'h9999, 1'b1, 1'b0, 16'h9999},
    {1'b0, 4'b0000, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h4000},
    {1'b1, 4'b0000, 8'h56, 16'hAAAA, 1'b0, 1'b1, 16'h8560},
    {1'b1, 4'b0000, 8'h56, 16'hAAAA, 1'b1, 1'b0, 16'hAAAA},
    {1'b0, 4'b0000, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h0000}
  };

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected control word per the parity rule (R6); clears the model accumulator.
  task automatic model_ctl(input logic [15:0] base, output logic [15:0] w);
    logic [15:0] x;
    logic [3:0]  p;
    x = {b_acc[14:0], b_acc[15]} ^ (base | 16'h000F);
    for (int i = 0; i < 4; i++) p[i] = x[i] ^ x[i+4] ^ x[i+8] ^ x[i+12];
    b_acc = '0;
    w = {base[15:4], p};
  endtask

  task automatic model_data(input logic [15:0] d);
    b_acc = {b_acc[14:0], b_acc[15]} ^ d;
  endtask

  task automatic train_exp(input int k, input logic [15:0] base0, output logic [16:0] e);
    logic [15:0] w;
    if (k == 0) begin
      model_ctl(base0, w);
      e = {1'b1, w};
    end else if (((k - 1) % 20) < 10) e = {1'b1, 16'h0FFF};
    else                              e = {1'b0, 16'hF000};
  endtask

  task automatic drive(input logic av, input logic [3:0] fl, input logic [7:0] pt,
                       input logic [15:0] d);
    in_avail = av;
    {in_sop, in_eop, in_err, in_odd} = fl;
    in_port = pt;
    in_data = d;
  endtask

  task automatic do_reset(input logic [15:0] gap);
    rst_n = 1'b0;
    cfg_train_gap = gap;
    stat_framing = 1'b0;
    drive(1'b0, 4'b0000, 8'h00, 16'h0000);
    @(negedge clk);
    chk("R1 reset output", {out_ctl, out_data}, {1'b1, 16'h000F});
    chk("R1 reset ready", {16'h0, in_ready}, 17'h0);
    @(negedge clk);
    rst_n = 1'b1;
    b_acc = '0;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [16:0] e;
    logic [15:0] w;
    string tag;

    // Table of bursts, port changes, gaps and end-of-packet variants (R2..R6).
    do_reset(16'd0);
    for (int i = 0; i < 22; i++) begin
      drive(VEC[i][46], VEC[i][45:42], VEC[i][41:34], VEC[i][33:18]);
      #1;
      chk(VEC[i][17] ? "R2 taken" : "R3 held", {16'h0, in_ready}, {16'h0, VEC[i][17]});
      @(negedge clk);
      if (!VEC[i][16]) begin
        model_data(VEC[i][15:0]);
        e = {1'b0, VEC[i][15:0]};
        tag = "R2 pass";
      end else begin
        model_ctl(VEC[i][15:0], w);
        e = {1'b1, w};
        if (VEC[i][14:13] != 2'b00) tag = "R4 R6 eop status";
        else if (VEC[i][15])        tag = "R3 R6 payload ctl";
        else                        tag = "R5 R6 idle";
      end
      chk(tag, {out_ctl, out_data}, e);
    end

    // Periodic training with gap 5, source starved (R7, R8).
    do_reset(16'd5);
    for (int c = 0; c < 212; c++) begin
      @(negedge clk);
      if (c < 5 || (c >= 206 && c < 211)) begin
        model_ctl(16'h0000, w);
        chk("R7 idle before training", {out_ctl, out_data}, {1'b1, w});
      end else begin
        train_exp((c < 206) ? c - 5 : c - 211, 16'h0000, e);
        chk((c == 5 || c == 211) ? "R7 training start" : "R8 training word",
            {out_ctl, out_data}, e);
      end
    end

    // Framing entered after an end-of-packet word (R8, R9, R10).
    do_reset(16'd0);
    for (int c = 0; c < 406; c++) begin
      if (c < 2) drive(1'b1, 4'b1100, 8'h21, 16'hBEEF);
      else       drive(1'b1, 4'b1000, 8'h21, 16'hCAFE);
      stat_framing = (c >= 2 && c <= 203);
      #1;
      if (c == 1 || c == 405) chk("R2 taken", {16'h0, in_ready}, 17'h1);
      else if (c >= 2)        chk("R8 no take in training", {16'h0, in_ready}, 17'h0);
      @(negedge clk);
      if (c == 0 || c == 404) begin
        model_ctl(16'h9210, w);
        e = {1'b1, w};
        tag = (c == 0) ? "R3 payload ctl" : "R10 resume ctl";
      end else if (c == 1 || c == 405) begin
        e = (c == 1) ? {1'b0, 16'hBEEF} : {1'b0, 16'hCAFE};
        model_data(e[15:0]);
        tag = "R2 pass";
      end else if (c <= 202) begin
        train_exp(c - 2, 16'h4000, e);
        tag = (c == 2) ? "R10 eop closed" : "R8 training word";
      end else begin
        train_exp(c - 203, 16'h0000, e);
        tag = (c == 203) ? "R9 back to back" : "R8 training word";
      end
      chk(tag, {out_ctl, out_data}, e);
    end

    // Reset in the middle of a sequence (R1).
    stat_framing = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset output", {out_ctl, out_data}, {1'b1, 16'h000F});
    chk("R1 async reset ready", {16'h0, in_ready}, 17'h0);

    // Gap zero disables periodic training (R7).
    do_reset(16'd0);
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      chk("R7 gap zero stays idle", {out_ctl, out_data}, {1'b1, 16'h000F});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule